// File: doc/BRIEF.md
# Buffered Two-Channel ADC Trigger Comparator

This block generates start-of-conversion pulses for an ADC. It sits next to a carrier counter that runs as a triangle, counting up and then down. It watches the counter value and a direction flag. It has two identical channels, A and B. Each channel compares the counter with its own active compare value and, on a match, issues a pulse one clock wide. Software never loads the active value directly. It writes a shadow (buffer) register, and that value is copied into the active register at a selectable carrier extreme: the crest, the trough, both, or never.

Each channel has an enable for the rising slope and an enable for the falling slope. Each channel can also be tied to either or both of two skip counters. One skip counter counts crest events and the other counts trough events. When a channel is tied to a skip counter, its triggers only pass in carrier periods that the counter lets through, so ADC sampling thins out in step with interrupt skipping.

A small FSM tracks the carrier slope. It has three states. `SL_INIT` is the state after reset, before any counter sample has been seen. `SL_UP` is the rising slope and `SL_DOWN` is the falling slope. The transitions are:

- *first sample*: `SL_INIT` to `SL_UP` or `SL_DOWN`, following the direction flag, with no event.
- *crest*: `SL_UP` to `SL_DOWN`, taken when the flag goes high. It raises the crest event.
- *trough*: `SL_DOWN` to `SL_UP`, taken when the flag goes low. It raises the trough event.

The direction flag changes on the clock after the counter reaches an extreme. Both events are therefore seen one clock after the extreme value.

Top module: `adc_trig_gen`

## Requirements
- R1: After reset, both active and both buffer registers hold all ones and the control register is zero, so no trigger is issued even when the counter equals all ones.
- R2: A write with `wr_addr` 0 loads control, 1 loads buffer A and 2 loads buffer B. A buffer write never changes the active value until a transfer takes place.
- R3: Control bits [1:0] select the transfer point: 00 never, 01 at a crest event, 10 at a trough event, 11 at both. The transfer happens on the clock edge where the slope FSM leaves one slope for the other.
- R4: A channel's trigger goes high for exactly one clock, in the cycle after a sampled counter value equals that channel's active value and that value passes its qualifiers.
- R5: A counter value held for consecutive cycles is evaluated only once, so a held match does not fire again.
- R6: The slope enables are control bit 2 (A rising), bit 3 (A falling), bit 4 (B rising) and bit 5 (B falling). `cnt_dn`=1 means falling. A match on a slope whose enable is clear produces no pulse.
- R7: Control bits [12:10] hold the crest skip count N and bits [15:13] hold the trough skip count M. Each skip counter sets its allow flag on one event out of N+1 (or M+1), starting with the (N+1)-th event after the count was loaded, and clears it on the others. A count of 0 allows every event.
- R8: The link bits are 6 (A to crest skip), 7 (A to trough skip), 8 (B to crest skip) and 9 (B to trough skip). A linked channel fires only while every linked allow flag is set.
- R9: Channels A and B are independent. A match on one channel never produces a pulse on the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 buffer A, 2 buffer B |
| wr_data | input | CW | Write data; control uses bits [15:0] |
| cnt_val | input | CW | Carrier counter value |
| cnt_dn | input | 1 | Carrier direction, 1 = counting down |
| trig_a | output | 1 | Channel A conversion start pulse |
| trig_b | output | 1 | Channel B conversion start pulse |

## Verification
The stimulus steps the counter through a small triangle and places compare values on the peak-adjacent points. The first group of corner cases covers the buffer and the slopes:
- A design that transferred at the wrong extreme, or on a buffer write, would fire one half-period early or late.
- A design that ignored the slope enables would fire on the disabled slope.
- A design that re-evaluated a held counter value would emit two pulses in a row.

The second group covers the skip gating and the transfer modes:
- With crest skip 1 and trough skip 2 linked to different channels, the expected pulse pattern repeats every two and every three periods. An off-by-one in the wrap logic shifts that pattern.
- Mode 00 followed by a buffer write must leave the old compare value in place.
- Mode 11 must reload at both a crest and a trough.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int CTRL_W = 16;
    localparam int SKIP_W = 3;
    localparam int NCH    = 2;
    localparam int NEXT   = 2;   // extreme kinds: 0 crest, 1 trough

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_BUF_A = 2'd1;

    typedef enum logic [1:0] {
        SL_INIT,
        SL_UP,
        SL_DOWN
    } slope_e;

    typedef struct packed {
        logic [SKIP_W-1:0] trough_skip;  // [15:13]
        logic [SKIP_W-1:0] crest_skip;   // [12:10]
        logic              b_lnk_tr;     // 9
        logic              b_lnk_cr;     // 8
        logic              a_lnk_tr;     // 7
        logic              a_lnk_cr;     // 6
        logic              b_dn;         // 5
        logic              b_up;         // 4
        logic              a_dn;         // 3
        logic              a_up;         // 2
        logic [1:0]        xfer;         // [1:0]
    } ctrl_t;

endpackage

// File: rtl/adc_trig_slope.sv
module adc_trig_slope
    import adc_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_dn,
    output logic crest_ev,
    output logic trough_ev
);

    slope_e st_q, st_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SL_INIT;
        else        st_q <= st_n;
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            SL_INIT: st_n = cnt_dn ? SL_DOWN : SL_UP;
            SL_UP:   if (cnt_dn)  st_n = SL_DOWN;
            SL_DOWN: if (!cnt_dn) st_n = SL_UP;
            default: st_n = SL_INIT;
        endcase
    end

    always_comb begin
        crest_ev  = 1'b0;
        trough_ev = 1'b0;
        unique case (st_q)
            SL_INIT: ;
            SL_UP:   crest_ev  = cnt_dn;
            SL_DOWN: trough_ev = !cnt_dn;
            default: ;
        endcase
    end

endmodule

// File: rtl/adc_trig_skip.sv
module adc_trig_skip #(
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev,
    input  logic [SW-1:0] limit,
    output logic          allow_o
);

    logic [SW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            allow_o <= 1'b0;
        end else if (ev) begin
            if (cnt_q >= limit) begin
                cnt_q   <= '0;
                allow_o <= 1'b1;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
                allow_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_trig_chan.sv
module adc_trig_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_we,
    input  logic [CW-1:0] buf_wd,
    input  logic          xfer_go,
    input  logic [CW-1:0] cnt_val,
    input  logic          cnt_new,
    input  logic          cnt_dn,
    input  logic          up_en,
    input  logic          dn_en,
    input  logic          lnk_cr,
    input  logic          lnk_tr,
    input  logic          allow_cr,
    input  logic          allow_tr,
    output logic [CW-1:0] act_o,
    output logic [CW-1:0] buf_o,
    output logic          trig_o
);

    logic slope_ok, skip_ok, hit;

    assign slope_ok = cnt_dn ? dn_en : up_en;
    assign skip_ok  = (!lnk_cr || allow_cr) && (!lnk_tr || allow_tr);
    assign hit      = cnt_new && (cnt_val == act_o) && slope_ok && skip_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      buf_o <= '1;
        else if (buf_we) buf_o <= buf_wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       act_o <= '1;
        else if (xfer_go) act_o <= buf_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_o <= 1'b0;
        else        trig_o <= hit;
    end

endmodule

// File: rtl/adc_trig_gen.sv
module adc_trig_gen
    import adc_trig_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [CW-1:0] cnt_val,
    input  logic          cnt_dn,
    output logic          trig_a,
    output logic          trig_b
);

    ctrl_t         ctrl_q;
    logic [CW-1:0] prev_val;
    logic          prev_ok;
    logic          cnt_new;
    logic          crest_ev, trough_ev, xfer_go;
    logic          ext_ev    [NEXT];
    logic [SKIP_W-1:0] ext_lim [NEXT];
    logic          allow     [NEXT];
    logic          up_en     [NCH];
    logic          dn_en     [NCH];
    logic          lnk_cr    [NCH];
    logic          lnk_tr    [NCH];
    logic [CW-1:0] act_q     [NCH];
    logic [CW-1:0] buf_q     [NCH];
    logic          trig_v    [NCH];

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              ctrl_q <= '0;
        else if (wr_en && wr_addr == ADDR_CTRL)  ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    // one evaluation per distinct counter sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_val <= '0;
            prev_ok  <= 1'b0;
        end else begin
            prev_val <= cnt_val;
            prev_ok  <= 1'b1;
        end
    end
    assign cnt_new = !prev_ok || (cnt_val != prev_val);

    adc_trig_slope u_slope (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_dn    (cnt_dn),
        .crest_ev  (crest_ev),
        .trough_ev (trough_ev)
    );

    assign xfer_go = (crest_ev && ctrl_q.xfer[0]) || (trough_ev && ctrl_q.xfer[1]);

    assign ext_ev[0]  = crest_ev;
    assign ext_ev[1]  = trough_ev;
    assign ext_lim[0] = ctrl_q.crest_skip;
    assign ext_lim[1] = ctrl_q.trough_skip;

    for (genvar e = 0; e < NEXT; e++) begin : g_skip
        adc_trig_skip #(.SW(SKIP_W)) u_skip (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev      (ext_ev[e]),
            .limit   (ext_lim[e]),
            .allow_o (allow[e])
        );
    end

    assign up_en[0]  = ctrl_q.a_up;
    assign dn_en[0]  = ctrl_q.a_dn;
    assign lnk_cr[0] = ctrl_q.a_lnk_cr;
    assign lnk_tr[0] = ctrl_q.a_lnk_tr;
    assign up_en[1]  = ctrl_q.b_up;
    assign dn_en[1]  = ctrl_q.b_dn;
    assign lnk_cr[1] = ctrl_q.b_lnk_cr;
    assign lnk_tr[1] = ctrl_q.b_lnk_tr;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        localparam logic [1:0] CH_ADDR = 2'(int'(ADDR_BUF_A) + c);
        adc_trig_chan #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .buf_we   (wr_en && wr_addr == CH_ADDR),
            .buf_wd   (wr_data),
            .xfer_go  (xfer_go),
            .cnt_val  (cnt_val),
            .cnt_new  (cnt_new),
            .cnt_dn   (cnt_dn),
            .up_en    (up_en[c]),
            .dn_en    (dn_en[c]),
            .lnk_cr   (lnk_cr[c]),
            .lnk_tr   (lnk_tr[c]),
            .allow_cr (allow[0]),
            .allow_tr (allow[1]),
            .act_o    (act_q[c]),
            .buf_o    (buf_q[c]),
            .trig_o   (trig_v[c])
        );
    end

    assign trig_a = trig_v[0];
    assign trig_b = trig_v[1];

endmodule

// File: rtl/adc_trig_chk.sv
module adc_trig_chk
    import adc_trig_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cnt_val,
    input logic          cnt_dn,
    input ctrl_t         ctrl,
    input logic          crest_ev,
    input logic          trough_ev,
    input logic          allow_cr,
    input logic          allow_tr,
    input logic [CW-1:0] act_a,
    input logic [CW-1:0] act_b,
    input logic [CW-1:0] buf_a,
    input logic [CW-1:0] buf_b,
    input logic          trig_a,
    input logic          trig_b
);

    logic xfer;
    assign xfer = (crest_ev && ctrl.xfer[0]) || (trough_ev && ctrl.xfer[1]);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!trig_a && !trig_b)
                else $error("trigger during reset");
        end
    end

    // R2
    hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> ($stable(act_a) && $stable(act_b)));

    // R3
    load_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (act_a == $past(buf_a) && act_b == $past(buf_b)));

    // R4
    match_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_a |-> ($past(cnt_val) == $past(act_a)));

    // R4
    match_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_b |-> ($past(cnt_val) == $past(act_b)));

    // R5
    no_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cnt_val == $past(cnt_val)) |=> (!trig_a && !trig_b));

    // R6
    slope_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_a |-> ($past(cnt_dn) ? $past(ctrl.a_dn) : $past(ctrl.a_up)));

    // R6
    slope_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_b |-> ($past(cnt_dn) ? $past(ctrl.b_dn) : $past(ctrl.b_up)));

    // R8
    link_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_a |-> ((!$past(ctrl.a_lnk_cr) || $past(allow_cr)) &&
                    (!$past(ctrl.a_lnk_tr) || $past(allow_tr))));

    // R8
    link_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_b |-> ((!$past(ctrl.b_lnk_cr) || $past(allow_cr)) &&
                    (!$past(ctrl.b_lnk_tr) || $past(allow_tr))));

    // R7
    skip_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crest_ev && ctrl.crest_skip == '0) |=> allow_cr);

endmodule

bind adc_trig_gen adc_trig_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_val   (cnt_val),
    .cnt_dn    (cnt_dn),
    .ctrl      (ctrl_q),
    .crest_ev  (crest_ev),
    .trough_ev (trough_ev),
    .allow_cr  (allow[0]),
    .allow_tr  (allow[1]),
    .act_a     (act_q[0]),
    .act_b     (act_q[1]),
    .buf_a     (buf_q[0]),
    .buf_b     (buf_q[1]),
    .trig_a    (trig_a),
    .trig_b    (trig_b)
);

// File: tb/sim_adc_trig_gen.sv
module sim_adc_trig_gen;

    localparam int CW = 16;
    localparam int NV = 56;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [CW-1:0] cnt_val = '0;
    logic          cnt_dn = 1'b0;
    logic          trig_a, trig_b;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    adc_trig_gen #(.CW(CW)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cnt_val (cnt_val),
        .cnt_dn  (cnt_dn),
        .trig_a  (trig_a),
        .trig_b  (trig_b)
    );

    // {req, we, addr, data, count, down, exp_a, exp_b}
    // ctrl 0x001E: trough transfer, A up+down, B up.  0x0029: crest transfer, A down, B down.
    // 0x467C: no transfer, all slopes, A linked to crest skip (N=1), B linked to trough skip (M=2).
    localparam logic [41:0] VEC [NV] = '{
        {4'd2, 1'b1, 2'd1, 16'h0002, 16'd0, 1'b0, 1'b0, 1'b0},  // R2 buffer A = 2
        {4'd2, 1'b1, 2'd2, 16'h0003, 16'd0, 1'b0, 1'b0, 1'b0},  // R2 buffer B = 3
        {4'd2, 1'b1, 2'd0, 16'h001E, 16'd1, 1'b0, 1'b0, 1'b0},
        {4'd2, 1'b0, 2'd0, 16'h0000, 16'd2, 1'b0, 1'b0, 1'b0},  // R2 buffer not active yet
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd3, 1'b0, 1'b0, 1'b0},
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd4, 1'b0, 1'b0, 1'b0},
        {4'd3, 1'b0, 2'd0, 16'h0000, 16'd3, 1'b1, 1'b0, 1'b0},  // R3 crest, no load in mode 10
        {4'd3, 1'b0, 2'd0, 16'h0000, 16'd2, 1'b1, 1'b0, 1'b0},
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd1, 1'b1, 1'b0, 1'b0},
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd0, 1'b1, 1'b0, 1'b0},
        {4'd3, 1'b0, 2'd0, 16'h0000, 16'd1, 1'b0, 1'b0, 1'b0},  // R3 trough load
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd2, 1'b0, 1'b1, 1'b0},  // R4 A fires
        {4'd5, 1'b0, 2'd0, 16'h0000, 16'd2, 1'b0, 1'b0, 1'b0},  // R5 held value
        {4'd9, 1'b0, 2'd0, 16'h0000, 16'd3, 1'b0, 1'b0, 1'b1},  // R9 only B
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd4, 1'b0, 1'b0, 1'b0},
        {4'd6, 1'b0, 2'd0, 16'h0000, 16'd3, 1'b1, 1'b0, 1'b0},  // R6 B down disabled
        {4'd6, 1'b0, 2'd0, 16'h0000, 16'd2, 1'b1, 1'b1, 1'b0},  // R6 A down enabled
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd1, 1'b1, 1'b0, 1'b0},
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd0, 1'b1, 1'b0, 1'b0},
        {4'd3, 1'b0, 2'd0, 16'h0000, 16'd1, 1'b0, 1'b0, 1'b0},
        {4'd2, 1'b1, 2'd0, 16'h0029, 16'd1, 1'b0, 1'b0, 1'b0},
        {4'd6, 1'b1, 2'd1, 16'h0001, 16'd2, 1'b0, 1'b0, 1'b0},  // R6 A up disabled
        {4'd6, 1'b0, 2'd0, 16'h0000, 16'd3, 1'b0, 1'b0, 1'b0},
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd4, 1'b0, 1'b0, 1'b0},
        {4'd3, 1'b0, 2'd0, 16'h0000, 16'd3, 1'b1, 1'b0, 1'b1},  // R3 crest load, B down fires
        {4'd3, 1'b0, 2'd0, 16'h0000, 16'd2, 1'b1, 1'b0, 1'b0},
        {4'd3, 1'b0, 2'd0, 16'h0000, 16'd1, 1'b1, 1'b1, 1'b0},  // R3 new A value
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd0, 1'b1, 1'b0, 1'b0},
        {4'd6, 1'b0, 2'd0, 16'h0000, 16'd1, 1'b0, 1'b0, 1'b0},
        {4'd7, 1'b1, 2'd0, 16'h467C, 16'd1, 1'b0, 1'b0, 1'b0},
        {4'd3, 1'b1, 2'd1, 16'h0000, 16'd2, 1'b0, 1'b0, 1'b0},  // R3 mode 00 ignores buffer
        {4'd8, 1'b0, 2'd0, 16'h0000, 16'd3, 1'b0, 1'b0, 1'b1},  // R8
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd4, 1'b0, 1'b0, 1'b0},
        {4'd8, 1'b0, 2'd0, 16'h0000, 16'd3, 1'b1, 1'b0, 1'b1},
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd2, 1'b1, 1'b0, 1'b0},
        {4'd7, 1'b0, 2'd0, 16'h0000, 16'd1, 1'b1, 1'b0, 1'b0},  // R7 crest skipped
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd0, 1'b1, 1'b0, 1'b0},
        {4'd7, 1'b0, 2'd0, 16'h0000, 16'd1, 1'b0, 1'b0, 1'b0},
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd2, 1'b0, 1'b0, 1'b0},
        {4'd7, 1'b0, 2'd0, 16'h0000, 16'd3, 1'b0, 1'b0, 1'b0},  // R7 trough skipped
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd4, 1'b0, 1'b0, 1'b0},
        {4'd7, 1'b0, 2'd0, 16'h0000, 16'd3, 1'b1, 1'b0, 1'b0},
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd2, 1'b1, 1'b0, 1'b0},
        {4'd7, 1'b0, 2'd0, 16'h0000, 16'd1, 1'b1, 1'b1, 1'b0},  // R7 crest allowed
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd0, 1'b1, 1'b0, 1'b0},
        {4'd7, 1'b0, 2'd0, 16'h0000, 16'd1, 1'b0, 1'b1, 1'b0},
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd2, 1'b0, 1'b0, 1'b0},
        {4'd7, 1'b0, 2'd0, 16'h0000, 16'd3, 1'b0, 1'b0, 1'b0},
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd4, 1'b0, 1'b0, 1'b0},
        {4'd7, 1'b0, 2'd0, 16'h0000, 16'd3, 1'b1, 1'b0, 1'b0},
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd2, 1'b1, 1'b0, 1'b0},
        {4'd7, 1'b0, 2'd0, 16'h0000, 16'd1, 1'b1, 1'b0, 1'b0},
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd0, 1'b1, 1'b0, 1'b0},
        {4'd7, 1'b0, 2'd0, 16'h0000, 16'd1, 1'b0, 1'b0, 1'b0},
        {4'd4, 1'b0, 2'd0, 16'h0000, 16'd2, 1'b0, 1'b0, 1'b0},
        {4'd7, 1'b0, 2'd0, 16'h0000, 16'd3, 1'b0, 1'b0, 1'b1}   // R7 third trough allowed
    };

    task automatic check(input int req, input logic ea, input logic eb);
        n_chk++;
        if (trig_a !== ea || trig_b !== eb) begin
            n_bad++;
            $display("FAIL R%0d: trig_a,trig_b = %b,%b expected %b,%b at %0t",
                     req, trig_a, trig_b, ea, eb, $time);
        end
    endtask

    task automatic step(input int req, input logic we, input logic [1:0] ad,
                        input logic [CW-1:0] wd, input logic [CW-1:0] cv,
                        input logic dn, input logic ea, input logic eb);
        wr_en   = we;
        wr_addr = ad;
        wr_data = wd;
        cnt_val = cv;
        cnt_dn  = dn;
        @(posedge clk);
        @(negedge clk);
        check(req, ea, eb);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL run: watchdog expired, actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1, 1'b0, 1'b0);                 // R1 quiet in reset
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(int'(VEC[i][41:38]), VEC[i][37], VEC[i][36:35], VEC[i][34:19],
                 VEC[i][18:3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R1: reset returns everything to all ones / disabled
        wr_en = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(1, 1'b0, 1'b0);
        rst_n = 1'b1;
        step(1, 1'b0, 2'd0, 16'h0000, 16'hFFFF, 1'b0, 1'b0, 1'b0);
        step(1, 1'b0, 2'd0, 16'h0000, 16'hFFFE, 1'b1, 1'b0, 1'b0);
        step(1, 1'b0, 2'd0, 16'h0000, 16'hFFFF, 1'b0, 1'b0, 1'b0);

        // R3: mode 11 reloads at crest and at trough
        step(2, 1'b1, 2'd1, 16'h0005, 16'd4, 1'b0, 1'b0, 1'b0);
        step(2, 1'b1, 2'd0, 16'h000F, 16'd4, 1'b0, 1'b0, 1'b0);
        step(3, 1'b0, 2'd0, 16'h0000, 16'd5, 1'b0, 1'b0, 1'b0);
        step(3, 1'b0, 2'd0, 16'h0000, 16'd6, 1'b1, 1'b0, 1'b0);
        step(3, 1'b0, 2'd0, 16'h0000, 16'd5, 1'b1, 1'b1, 1'b0);
        step(3, 1'b1, 2'd1, 16'h0006, 16'd4, 1'b1, 1'b0, 1'b0);
        step(3, 1'b0, 2'd0, 16'h0000, 16'd3, 1'b0, 1'b0, 1'b0);
        step(3, 1'b0, 2'd0, 16'h0000, 16'd4, 1'b0, 1'b0, 1'b0);
        step(3, 1'b0, 2'd0, 16'h0000, 16'd5, 1'b0, 1'b0, 1'b0);
        step(3, 1'b0, 2'd0, 16'h0000, 16'd6, 1'b0, 1'b1, 1'b0);

        finish_run();
    end

endmodule